// File: doc/BRIEF.md
# Conditional-Move Map-Cycle Splitter

This block sits between instruction fetch and the rename mappers. Fetch presents a line of four slots with a handshake. Each slot carries a valid bit and a flag that marks it as a conditional move. The rename stage can only handle two-operand operations, so every conditional move is split into two micro-ops. The first half tests the predicate, and the second half selects the result. The two halves must reach the mappers in consecutive cycles.

The block emits one group per map cycle, in program order. A group always closes right after a first-half micro-op. The next group, on the very next cycle, opens with the matching second half. A line with n conditional moves therefore takes n+1 map cycles. While a line is still draining, the block holds back fetch by dropping its ready output. A line without conditional moves goes through in one cycle, and lines of that kind can follow one another on every clock. Each output lane carries a valid bit, a kind field and the index of the slot it came from.

Top module: `cmov_split_top`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and all out_lane_valid bits are 0.
- R2: A line with at least one valid slot and no conditional move is emitted as a single group in the cycle after it is accepted. All its ops have kind 2'b00 (plain), and in_ready stays 1, so such lines can be accepted and emitted on consecutive cycles with no bubble.
- R3: Each valid conditional-move slot produces two micro-ops that carry the same slot index. The first half has kind 2'b01 and the second half has kind 2'b10.
- R4: A group ends right after a first-half micro-op. The group on the next cycle starts in lane 0 with the matching second half, and a second half never appears in any lane other than lane 0.
- R5: A line holding n valid conditional moves produces exactly n+1 groups, on n+1 consecutive cycles starting the cycle after acceptance.
- R6: After a line with n ≥ 1 conditional moves is accepted, in_ready is 0 while groups 1 to n are on the outputs. It returns to 1 in the cycle that shows the last group.
- R7: Line inputs and in_valid presented while in_ready is 0 are ignored, and the held line drains unchanged.
- R8: Invalid slots are skipped. Emitted ops fill lanes from lane 0 upward with no gaps, in slot order. Lane j reports its kind in out_lane_kind[2j+1:2j] and its original slot index in out_lane_slot[2j+1:2j]. Unused lanes read 0 in all fields.
- R9: A line with no valid slots is accepted, produces no group (out_valid stays 0), and leaves in_ready at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fetch presents a line |
| in_ready | output | 1 | Splitter can accept a line this cycle |
| in_slot_valid | input | 4 | Per-slot valid bits of the line |
| in_slot_cmov | input | 4 | Per-slot conditional-move flags |
| out_valid | output | 1 | A group is presented to rename |
| out_lane_valid | output | 4 | Per-lane valid bits of the group |
| out_lane_kind | output | 8 | Per-lane kind, 2 bits each (00 plain, 01 first half, 10 second half) |
| out_lane_slot | output | 8 | Per-lane original slot index, 2 bits each |

## Verification
The bench drives lines chosen to stress the group boundaries. These include a conditional move in the last slot, so that the final group holds only a lone second half. They also include a line of four conditional moves, which gives five groups, and sparse lines with holes, which check that lanes are repacked while the original slot index is kept. A design that closes a group in the wrong place, or sends a second half early, shows wrong lane contents or a wrong group count. A design with an off-by-one in the ready logic either loses a line or lets fetch overwrite a line that is still draining; the bench catches this by driving inverted junk lines during the drain. Back-to-back plain lines and an empty line expose any inserted bubble or any phantom group.

// File: rtl/cmov_split_pkg.sv
package cmov_split_pkg;

   localparam int KIND_W = 2;

   typedef enum logic [KIND_W-1:0] {
      UOP_PLAIN  = 2'b00,
      UOP_FIRST  = 2'b01,
      UOP_SECOND = 2'b10
   } uop_kind_e;

endpackage

// File: rtl/cmov_split_group_builder.sv
module cmov_split_group_builder
   import cmov_split_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = 2
) (
   input  logic [LANES-1:0]        src_valid,
   input  logic [LANES-1:0]        src_cmov,
   input  logic [IDX_W-1:0]        cur_slot,
   input  logic                    resume_second,
   output logic [LANES-1:0]        grp_valid,
   output logic [LANES*KIND_W-1:0] grp_kind,
   output logic [LANES*IDX_W-1:0]  grp_slot,
   output logic [IDX_W-1:0]        nxt_slot,
   output logic                    nxt_second,
   output logic                    grp_last
);

   // Walk the slots from the cursor and pack ops into lanes.
   // The walk stops right after a first-half op.
   always_comb begin
      int   lane;
      logic stop;
      grp_valid  = '0;
      grp_kind   = '0;
      grp_slot   = '0;
      nxt_slot   = cur_slot;
      nxt_second = 1'b0;
      grp_last   = 1'b1;
      lane       = 0;
      stop       = 1'b0;
      for (int k = 0; k < LANES; k++) begin
         if (!stop && src_valid[k] && (k >= int'(cur_slot)) && (lane < LANES)) begin
            grp_valid[lane]                = 1'b1;
            grp_slot[lane*IDX_W +: IDX_W]  = IDX_W'(k);
            if (resume_second && (k == int'(cur_slot))) begin
               grp_kind[lane*KIND_W +: KIND_W] = UOP_SECOND;
            end else if (src_cmov[k]) begin
               grp_kind[lane*KIND_W +: KIND_W] = UOP_FIRST;
               stop       = 1'b1;
               nxt_slot   = IDX_W'(k);
               nxt_second = 1'b1;
               grp_last   = 1'b0;
            end else begin
               grp_kind[lane*KIND_W +: KIND_W] = UOP_PLAIN;
            end
            lane = lane + 1;
         end
      end
   end

endmodule

// File: rtl/cmov_split_line_ctrl.sv
module cmov_split_line_ctrl #(
   parameter int LANES = 4,
   parameter int IDX_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic [LANES-1:0] in_slot_valid,
   input  logic [LANES-1:0] in_slot_cmov,
   input  logic             grp_last,
   input  logic [IDX_W-1:0] nxt_slot,
   input  logic             nxt_second,
   output logic             in_ready,
   output logic             fire,
   output logic [LANES-1:0] src_valid,
   output logic [LANES-1:0] src_cmov,
   output logic [IDX_W-1:0] src_cur,
   output logic             src_second
);

   logic             busy_q;
   logic [LANES-1:0] held_valid_q;
   logic [LANES-1:0] held_cmov_q;
   logic [IDX_W-1:0] cur_q;
   logic             second_q;
   logic             take;

   assign in_ready = !busy_q;
   assign take     = in_valid && !busy_q;
   assign fire     = take || busy_q;

   // While draining, the held remainder feeds the builder; else the live line.
   assign src_valid  = busy_q ? held_valid_q : in_slot_valid;
   assign src_cmov   = busy_q ? held_cmov_q  : in_slot_cmov;
   assign src_cur    = busy_q ? cur_q        : '0;
   assign src_second = busy_q ? second_q     : 1'b0;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q       <= 1'b0;
         held_valid_q <= '0;
         held_cmov_q  <= '0;
         cur_q        <= '0;
         second_q     <= 1'b0;
      end else if (take) begin
         held_valid_q <= in_slot_valid;
         held_cmov_q  <= in_slot_cmov;
         if (!grp_last) begin
            busy_q   <= 1'b1;
            cur_q    <= nxt_slot;
            second_q <= nxt_second;
         end
      end else if (busy_q) begin
         if (grp_last) begin
            busy_q   <= 1'b0;
            second_q <= 1'b0;
         end else begin
            cur_q    <= nxt_slot;
            second_q <= nxt_second;
         end
      end
   end

   // R5: every extra map cycle moves the cursor to a later slot
   a_r5_cursor_advances: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && !grp_last) |=> (busy_q && (cur_q > $past(cur_q))));

   // R7: the held line does not change while draining
   a_r7_held_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && $past(busy_q)) |-> ($stable(held_valid_q) && $stable(held_cmov_q)));

endmodule

// File: rtl/cmov_split_out_stage.sv
module cmov_split_out_stage
   import cmov_split_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    fire,
   input  logic [LANES-1:0]        grp_valid,
   input  logic [LANES*KIND_W-1:0] grp_kind,
   input  logic [LANES*IDX_W-1:0]  grp_slot,
   output logic                    out_valid,
   output logic [LANES-1:0]        out_lane_valid,
   output logic [LANES*KIND_W-1:0] out_lane_kind,
   output logic [LANES*IDX_W-1:0]  out_lane_slot
);

   always_ff @(posedge clk) begin
      if (!rst_n || !fire) begin
         out_valid      <= 1'b0;
         out_lane_valid <= '0;
         out_lane_kind  <= '0;
         out_lane_slot  <= '0;
      end else begin
         out_valid      <= grp_valid[0];
         out_lane_valid <= grp_valid;
         out_lane_kind  <= grp_kind;
         out_lane_slot  <= grp_slot;
      end
   end

endmodule

// File: rtl/cmov_split_top.sv
module cmov_split_top
   import cmov_split_pkg::*;
#(
   parameter int LANES = 4,
   parameter int IDX_W = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [LANES-1:0]        in_slot_valid,
   input  logic [LANES-1:0]        in_slot_cmov,
   output logic                    out_valid,
   output logic [LANES-1:0]        out_lane_valid,
   output logic [LANES*KIND_W-1:0] out_lane_kind,
   output logic [LANES*IDX_W-1:0]  out_lane_slot
);

   generate
      if (LANES < 2 || LANES > 16) begin : g_bad_lanes
         $error("cmov_split_top: LANES must lie in 2..16");
      end
      if ((1 << IDX_W) < LANES) begin : g_bad_idx
         $error("cmov_split_top: IDX_W too narrow for LANES");
      end
   endgenerate

   logic                    fire;
   logic [LANES-1:0]        src_valid;
   logic [LANES-1:0]        src_cmov;
   logic [IDX_W-1:0]        src_cur;
   logic                    src_second;
   logic [LANES-1:0]        grp_valid;
   logic [LANES*KIND_W-1:0] grp_kind;
   logic [LANES*IDX_W-1:0]  grp_slot;
   logic [IDX_W-1:0]        nxt_slot;
   logic                    nxt_second;
   logic                    grp_last;

   cmov_split_line_ctrl #(.LANES(LANES), .IDX_W(IDX_W)) ctrl_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .in_valid     (in_valid),
      .in_slot_valid(in_slot_valid),
      .in_slot_cmov (in_slot_cmov),
      .grp_last     (grp_last),
      .nxt_slot     (nxt_slot),
      .nxt_second   (nxt_second),
      .in_ready     (in_ready),
      .fire         (fire),
      .src_valid    (src_valid),
      .src_cmov     (src_cmov),
      .src_cur      (src_cur),
      .src_second   (src_second)
   );

   cmov_split_group_builder #(.LANES(LANES), .IDX_W(IDX_W)) build_i (
      .src_valid    (src_valid),
      .src_cmov     (src_cmov),
      .cur_slot     (src_cur),
      .resume_second(src_second),
      .grp_valid    (grp_valid),
      .grp_kind     (grp_kind),
      .grp_slot     (grp_slot),
      .nxt_slot     (nxt_slot),
      .nxt_second   (nxt_second),
      .grp_last     (grp_last)
   );

   cmov_split_out_stage #(.LANES(LANES), .IDX_W(IDX_W)) out_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .fire          (fire),
      .grp_valid     (grp_valid),
      .grp_kind      (grp_kind),
      .grp_slot      (grp_slot),
      .out_valid     (out_valid),
      .out_lane_valid(out_lane_valid),
      .out_lane_kind (out_lane_kind),
      .out_lane_slot (out_lane_slot)
   );

   // ---------------- assertions ----------------
   // Find whether the emitted group closes on a first half, and its slot.
   logic             grp_ends_first;
   logic [IDX_W-1:0] grp_end_slot;
   always_comb begin
      grp_ends_first = 1'b0;
      grp_end_slot   = '0;
      for (int j = 0; j < LANES; j++) begin
         if (out_lane_valid[j]) begin
            grp_ends_first = (out_lane_kind[j*KIND_W +: KIND_W] == UOP_FIRST);
            grp_end_slot   = out_lane_slot[j*IDX_W +: IDX_W];
         end
      end
   end

   // R4: a group closing on a first half is followed by its second half in lane 0
   a_r4_second_follows: assert property (@(posedge clk) disable iff (!rst_n)
      grp_ends_first |=> (out_lane_valid[0] &&
                          (out_lane_kind[KIND_W-1:0] == UOP_SECOND) &&
                          (out_lane_slot[IDX_W-1:0] == $past(grp_end_slot))));

   // R6: while fetch is held off, a group comes out on every cycle
   a_r6_drain_emits: assert property (@(posedge clk) disable iff (!rst_n)
      !in_ready |=> out_valid);

   // R2: a plain-only non-empty line goes out next cycle with ready kept high
   a_r2_plain_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (|in_slot_valid) && ((in_slot_valid & in_slot_cmov) == '0))
      |=> (out_valid && in_ready));

   // R9: an empty line leaves no group behind
   a_r9_empty_line: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && (in_slot_valid == '0)) |=> (!out_valid && in_ready));

   // R8: out_valid mirrors lane 0
   a_r8_valid_lane0: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid == out_lane_valid[0]);

   generate
      for (genvar j = 1; j < LANES; j++) begin : g_lane_chk
         // R8: lanes are packed from lane 0
         a_r8_lanes_packed: assert property (@(posedge clk) disable iff (!rst_n)
            out_lane_valid[j] |-> out_lane_valid[j-1]);
         // R4: second half only ever in lane 0
         a_r4_second_lane0: assert property (@(posedge clk) disable iff (!rst_n)
            out_lane_valid[j] |-> (out_lane_kind[j*KIND_W +: KIND_W] != UOP_SECOND));
         // R4: nothing follows a first half within a group
         a_r4_first_closes: assert property (@(posedge clk) disable iff (!rst_n)
            out_lane_valid[j] |-> (out_lane_kind[(j-1)*KIND_W +: KIND_W] != UOP_FIRST));
      end
   endgenerate

endmodule

// File: tb/cmov_split_top_tb_top.sv
module cmov_split_top_tb_top;

   localparam logic [1:0] K_PL = 2'b00;
   localparam logic [1:0] K_F1 = 2'b01;
   localparam logic [1:0] K_F2 = 2'b10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_ready;
   logic [3:0] in_slot_valid = '0;
   logic [3:0] in_slot_cmov = '0;
   logic       out_valid;
   logic [3:0] out_lane_valid;
   logic [7:0] out_lane_kind;
   logic [7:0] out_lane_slot;

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;
   bit done = 0;

   // expected groups for one line
   logic [3:0] ev[5];
   logic [7:0] ek[5];
   logic [7:0] es[5];
   int ng;
   int lane;
   bit open;

   always #10 clk = ~clk;

   cmov_split_top dut_i (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_slot_valid(in_slot_valid), .in_slot_cmov(in_slot_cmov),
      .out_valid(out_valid), .out_lane_valid(out_lane_valid),
      .out_lane_kind(out_lane_kind), .out_lane_slot(out_lane_slot));

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic add_op(input logic [1:0] kind, input int k);
      if (!open) begin
         ev[ng] = '0; ek[ng] = '0; es[ng] = '0;
         open = 1; lane = 0;
      end
      ev[ng][lane]       = 1'b1;
      ek[ng][2*lane +: 2] = kind;
      es[ng][2*lane +: 2] = 2'(k);
      lane++;
      if (kind == K_F1) begin
         ng++;
         open = 0;
      end
   endtask

   // Expected micro-op stream in program order, cut after every first half.
   task automatic build_expect(input logic [3:0] v, input logic [3:0] c);
      ng = 0; lane = 0; open = 0;
      for (int k = 0; k < 4; k++) begin
         if (v[k]) begin
            if (c[k]) begin
               add_op(K_F1, k);
               add_op(K_F2, k);
            end else begin
               add_op(K_PL, k);
            end
         end
      end
      if (open) ng++;
   endtask

   task automatic run_line(input logic [3:0] v, input logic [3:0] c, input bit junk, input string tag);
      build_expect(v, c);
      @(negedge clk);
      chk(32'(in_ready), 1, {tag, " R6 ready before accept"});
      in_valid = 1'b1; in_slot_valid = v; in_slot_cmov = c;
      @(negedge clk);
      if (junk && ng > 1) begin
         in_slot_valid = ~v; in_slot_cmov = ~c;   // R7: must be ignored
      end else begin
         in_valid = 1'b0;
      end
      if (ng == 0) begin
         chk(32'(out_valid), 0, {tag, " R9 empty line no group"});
         chk(32'(in_ready), 1, {tag, " R9 ready stays high"});
         @(negedge clk);
      end
      for (int g = 0; g < ng; g++) begin
         chk(32'(out_valid), 1, {tag, " R5 group present"});
         chk(32'(out_lane_valid), 32'(ev[g]), {tag, " R8 lane valid"});
         chk(32'(out_lane_kind), 32'(ek[g]), {tag, " R3/R4 lane kind"});
         chk(32'(out_lane_slot), 32'(es[g]), {tag, " R8 lane slot"});
         chk(32'(in_ready), (g == ng - 1) ? 1 : 0, {tag, " R6 ready while draining"});
         if (g == ng - 1) in_valid = 1'b0;
         @(negedge clk);
      end
      chk(32'(out_valid), 0, {tag, " R5 no extra group"});
   endtask

   task automatic test_reset();
      chk(32'(in_ready), 1, "R1 reset in_ready");
      chk(32'(out_valid), 0, "R1 reset out_valid");
      chk(32'(out_lane_valid), 0, "R1 reset lane valid");
   endtask

   task automatic test_stream_plain();
      @(negedge clk);
      in_valid = 1'b1; in_slot_valid = 4'b1111; in_slot_cmov = 4'b0000;
      @(negedge clk);
      chk(32'(out_lane_valid), 32'h0f, "R2 stream line A valid");
      chk(32'(out_lane_kind), 32'h00, "R2 stream line A kind");
      chk(32'(out_lane_slot), 32'he4, "R2 stream line A slots");
      chk(32'(in_ready), 1, "R2 ready stays high A");
      in_slot_valid = 4'b0110;
      @(negedge clk);
      chk(32'(out_lane_valid), 32'h03, "R2 stream line B valid");
      chk(32'(out_lane_slot), 32'h09, "R2 stream line B slots");
      chk(32'(in_ready), 1, "R2 ready stays high B");
      in_slot_valid = 4'b1000;
      @(negedge clk);
      chk(32'(out_lane_valid), 32'h01, "R2 stream line C valid");
      chk(32'(out_lane_slot), 32'h03, "R2 stream line C slot");
      in_valid = 1'b0;
      @(negedge clk);
      chk(32'(out_valid), 0, "R2 stream ends");
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 20000 && !done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=%0d expected=<20000 cycles", cycles);
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      run_line(4'b1111, 4'b0000, 0, "R2 all plain");
      test_stream_plain();
      run_line(4'b1111, 4'b1010, 0, "R5 plain-cmov-plain-cmov");
      run_line(4'b1111, 4'b1111, 1, "R7 four cmovs with junk");
      run_line(4'b1111, 4'b0001, 0, "R4 cmov in slot0");
      run_line(4'b1010, 4'b1000, 1, "R8 sparse with last cmov");
      run_line(4'b0101, 4'b0100, 0, "R8 sparse cmov slot2");
      run_line(4'b0000, 4'b1111, 0, "R9 empty");
      run_line(4'b0100, 4'b0100, 0, "R3 lone cmov");
      run_line(4'b1011, 4'b0100, 0, "R8 cmov flag on invalid slot");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule